// File: doc/BRIEF.md
# Serial PSRAM Protocol Frontend

This block is the device side of a serial pseudo-SRAM link. It watches an active-low chip select, a serial clock and four data lanes. From these it recovers each command byte, the 24-bit address and any write data, using one or four lanes per clock. The lane count depends on the current interface mode and on the opcode. For reads it counts the dummy clocks, then streams bytes back out. The interface mode is either single-lane or four-lane, and it persists across transactions until a command changes it.

Behind the frontend sits a synchronous byte-wide store. Its depth is set by a parameter, and it is reached through an internal read/write port. Bursts walk through consecutive bytes and stay inside a 1024-byte page. The analog power-up sequence is reduced to a ready input. After ready is high, the block also needs one clock with chip select high before it accepts commands.

Top module: `psram_serial_frontend`

## Requirements
- R1: While `init_done` has not yet been high on a rising `sclk` with `cs_n` high, every command is ignored: the mode is not changed, the store is not written and `sio_oe` stays 0.
- R2: Opcode 35h received in single-lane mode selects four-lane mode. Opcode F5h received in four-lane mode selects single-lane mode. 35h received in four-lane mode and F5h received in single-lane mode change nothing.
- R3: Single-lane write 02h: 8 opcode bits, then 24 address bits, then data bytes, all MSB first on `sio_in[0]`, one bit per clock, with no dummy clocks.
- R4: Single-lane read 03h: after the last address bit, data leaves MSB first on `sio_out[1]` with `sio_oe`=0010b, valid from the very next clock, with no dummy clocks.
- R5: Single-lane fast read 0Bh inserts exactly 8 dummy clocks between the last address bit and the first data bit.
- R6: In single-lane mode, opcode EBh (read) and opcode 38h (write) take the opcode on one lane. They then take the address as 6 nibbles and the data as nibbles on `sio_in[3:0]`/`sio_out[3:0]`, high nibble first. EBh adds 6 dummy clocks, and its data is driven with `sio_oe`=1111b.
- R7: In four-lane mode, the opcode is two nibbles, high nibble first. 0Bh and EBh read with a 6-nibble address and 6 dummy clocks. 02h and 38h write with a 6-nibble address. 03h is treated as an unknown opcode.
- R8: Within a burst, the byte address increments after each byte. The low 10 bits wrap from 3FFh to 000h, and the upper bits are held.
- R9: After an unknown opcode, no lane is driven and the store is untouched until `cs_n` rises.
- R10: `sio_oe` is 0 during the opcode, address and dummy phases and after reset. It returns to 0 as soon as `cs_n` is high, without waiting for a clock.
- R11: Inputs are sampled on the rising `sclk` edge. Output data changes only after a falling edge, so it is stable across the rising edge where the host samples it.
- R12: A rising `cs_n` ends the transaction. A partly received write byte is discarded, and the next low `cs_n` starts a new opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock from the host |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done | input | 1 | High once device power-up initialisation is complete |
| cs_n | input | 1 | Active-low chip select |
| sio_in | input | 4 | Lane input values; lane 0 only in single-lane phases |
| sio_out | output | 4 | Lane output values |
| sio_oe | output | 4 | Per-lane output enable |

## Verification
The assertions assume the following about the host:
- It holds `cs_n` high for at least one rising `sclk` to end every transaction.
- It changes lane inputs only while `sclk` is low.
- It never sends an address beyond the store's depth.

The bench drives every input from tasks while the clock is low. It closes each transaction with a clock that has chip select high, and it draws random addresses only below the store depth. It mixes directed mode changes, page-crossing bursts, unknown opcodes and a truncated write with random write-then-read pairs. Each random pair uses an opcode that is legal in the current mode.

// File: rtl/psram_fe_pkg.sv
package psram_fe_pkg;

  localparam int WAIT_W = 4;

  localparam logic [7:0] OPC_RD      = 8'h03;
  localparam logic [7:0] OPC_RD_FAST = 8'h0B;
  localparam logic [7:0] OPC_RD_QUAD = 8'hEB;
  localparam logic [7:0] OPC_WR      = 8'h02;
  localparam logic [7:0] OPC_WR_QUAD = 8'h38;
  localparam logic [7:0] OPC_GO_QUAD = 8'h35;
  localparam logic [7:0] OPC_GO_ONE  = 8'hF5;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_WAIT,
    ST_RDATA,
    ST_WDATA,
    ST_IGNORE
  } fe_state_t;

  typedef struct packed {
    logic              known;
    logic              rd;
    logic              wr;
    logic              go_quad;
    logic              go_one;
    logic              addr_quad;
    logic              data_quad;
    logic [WAIT_W-1:0] wait_clks;
  } cmd_info_t;

endpackage

// File: rtl/psram_cmd_decode.sv
module psram_cmd_decode
  import psram_fe_pkg::*;
#(
  parameter int SPI_FAST_WAIT = 8,
  parameter int QUAD_WAIT     = 6
) (
  input  logic [7:0] opcode,
  input  logic       qpi,
  output cmd_info_t  info
);

  localparam logic [WAIT_W-1:0] FAST_W = WAIT_W'(SPI_FAST_WAIT);
  localparam logic [WAIT_W-1:0] QUAD_W = WAIT_W'(QUAD_WAIT);

  always_comb begin
    info = '0;
    if (!qpi) begin
      unique case (opcode)
        OPC_RD: begin
          info.known = 1'b1;
          info.rd    = 1'b1;
        end
        OPC_RD_FAST: begin
          info.known     = 1'b1;
          info.rd        = 1'b1;
          info.wait_clks = FAST_W;
        end
        OPC_RD_QUAD: begin
          info.known     = 1'b1;
          info.rd        = 1'b1;
          info.addr_quad = 1'b1;
          info.data_quad = 1'b1;
          info.wait_clks = QUAD_W;
        end
        OPC_WR: begin
          info.known = 1'b1;
          info.wr    = 1'b1;
        end
        OPC_WR_QUAD: begin
          info.known     = 1'b1;
          info.wr        = 1'b1;
          info.addr_quad = 1'b1;
          info.data_quad = 1'b1;
        end
        OPC_GO_QUAD: begin
          info.known   = 1'b1;
          info.go_quad = 1'b1;
        end
        default: info = '0;
      endcase
    end else begin
      unique case (opcode)
        OPC_RD_FAST, OPC_RD_QUAD: begin
          info.known     = 1'b1;
          info.rd        = 1'b1;
          info.addr_quad = 1'b1;
          info.data_quad = 1'b1;
          info.wait_clks = QUAD_W;
        end
        OPC_WR, OPC_WR_QUAD: begin
          info.known     = 1'b1;
          info.wr        = 1'b1;
          info.addr_quad = 1'b1;
          info.data_quad = 1'b1;
        end
        OPC_GO_ONE: begin
          info.known  = 1'b1;
          info.go_one = 1'b1;
        end
        default: info = '0;
      endcase
    end
  end

endmodule

// File: rtl/psram_byte_store.sv
module psram_byte_store #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[addr] <= wdata;
    end
    if (re) begin
      rdata <= cells[addr];
    end
  end

endmodule

// File: rtl/psram_out_shifter.sv
module psram_out_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       quad,
  input  logic [7:0] load_data,
  input  logic       cs_n,
  output logic [3:0] sio_out,
  output logic [3:0] sio_oe
);

  logic [7:0] sh_q, sh_d;
  logic [2:0] ocnt_q, ocnt_d;
  logic       oe_q, oe_d;

  always_comb begin
    sh_d   = sh_q;
    ocnt_d = ocnt_q;
    oe_d   = oe_q;
    if (!active) begin
      ocnt_d = '0;
      oe_d   = 1'b0;
    end else if (ocnt_q == 3'd0) begin
      sh_d   = load_data;
      ocnt_d = quad ? 3'd1 : 3'd7;
      oe_d   = 1'b1;
    end else begin
      sh_d   = quad ? {sh_q[3:0], 4'h0} : {sh_q[6:0], 1'b0};
      ocnt_d = ocnt_q - 3'd1;
    end
  end

  // Output register advances on the falling edge so data is settled at the next rise
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      ocnt_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      ocnt_q <= ocnt_d;
      oe_q   <= oe_d;
    end
  end

  assign sio_out = quad ? sh_q[7:4] : {2'b00, sh_q[7], 1'b0};
  assign sio_oe  = (oe_q && !cs_n) ? (quad ? 4'b1111 : 4'b0010) : 4'b0000;

endmodule

// File: rtl/psram_serial_frontend.sv
module psram_serial_frontend
  import psram_fe_pkg::*;
#(
  parameter int ADDR_W        = 11,
  parameter int PAGE_W        = 10,
  parameter int SPI_FAST_WAIT = 8,
  parameter int QUAD_WAIT     = 6
) (
  input  logic       sclk,
  input  logic       rst_n,
  input  logic       init_done,
  input  logic       cs_n,
  input  logic [3:0] sio_in,
  output logic [3:0] sio_out,
  output logic [3:0] sio_oe
);

  localparam int SH_W = (ADDR_W > 8) ? ADDR_W : 8;

  // reset: asynchronous assert, release aligned to sclk
  logic [1:0] rst_sync;
  logic       rst_i;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_i = rst_sync[1];

  fe_state_t         state, state_d;
  logic              armed, armed_d;
  logic              qpi, qpi_d;
  logic [4:0]        cnt, cnt_d;
  logic [SH_W-1:0]   shreg, sh_d, sh_next;
  cmd_info_t         info_q, info_d, dec;
  logic [ADDR_W-1:0] ptr, ptr_d;
  logic [WAIT_W-1:0] wcnt, wcnt_d;
  logic [2:0]        rcnt, rcnt_d;

  logic              quad_lane;
  logic [4:0]        last_cnt;
  logic              phase_last;
  logic              mem_we, mem_re;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata, mem_rdata;
  logic              rd_active;
  logic              unused_bits;

  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
    page_next = {a[ADDR_W-1:PAGE_W], a[PAGE_W-1:0] + 1'b1};
  endfunction

  always_comb begin
    unique case (state)
      ST_CMD:  quad_lane = qpi;
      ST_ADDR: quad_lane = info_q.addr_quad;
      default: quad_lane = info_q.data_quad;
    endcase
    unique case (state)
      ST_CMD:  last_cnt = qpi ? 5'd1 : 5'd7;
      ST_ADDR: last_cnt = info_q.addr_quad ? 5'd5 : 5'd23;
      default: last_cnt = info_q.data_quad ? 5'd1 : 5'd7;
    endcase
  end

  assign phase_last = (cnt == last_cnt);
  assign sh_next    = quad_lane ? {shreg[SH_W-5:0], sio_in}
                                : {shreg[SH_W-2:0], sio_in[0]};

  psram_cmd_decode #(
    .SPI_FAST_WAIT (SPI_FAST_WAIT),
    .QUAD_WAIT     (QUAD_WAIT)
  ) i_decode (
    .opcode (sh_next[7:0]),
    .qpi    (qpi),
    .info   (dec)
  );

  // next-state logic
  always_comb begin
    state_d   = state;
    armed_d   = armed;
    qpi_d     = qpi;
    cnt_d     = cnt;
    sh_d      = shreg;
    info_d    = info_q;
    ptr_d     = ptr;
    wcnt_d    = wcnt;
    rcnt_d    = rcnt;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = ptr;
    mem_wdata = sh_next[7:0];
    if (cs_n) begin
      state_d = ST_CMD;
      cnt_d   = '0;
      if (init_done) begin
        armed_d = 1'b1;
      end
    end else if (armed) begin
      unique case (state)
        ST_CMD: begin
          sh_d  = sh_next;
          cnt_d = cnt + 5'd1;
          if (phase_last) begin
            cnt_d  = '0;
            info_d = dec;
            if (!dec.known) begin
              state_d = ST_IGNORE;
            end else if (dec.go_quad) begin
              qpi_d   = 1'b1;
              state_d = ST_IGNORE;
            end else if (dec.go_one) begin
              qpi_d   = 1'b0;
              state_d = ST_IGNORE;
            end else begin
              state_d = ST_ADDR;
            end
          end
        end
        ST_ADDR: begin
          sh_d  = sh_next;
          cnt_d = cnt + 5'd1;
          if (phase_last) begin
            cnt_d = '0;
            if (info_q.wr) begin
              state_d = ST_WDATA;
              ptr_d   = sh_next[ADDR_W-1:0];
            end else if (info_q.wait_clks == '0) begin
              state_d  = ST_RDATA;
              mem_re   = 1'b1;
              mem_addr = sh_next[ADDR_W-1:0];
              ptr_d    = page_next(sh_next[ADDR_W-1:0]);
              rcnt_d   = '0;
            end else begin
              state_d = ST_WAIT;
              ptr_d   = sh_next[ADDR_W-1:0];
              wcnt_d  = '0;
            end
          end
        end
        ST_WAIT: begin
          if (wcnt == info_q.wait_clks - 1'b1) begin
            state_d = ST_RDATA;
            mem_re  = 1'b1;
            ptr_d   = page_next(ptr);
            rcnt_d  = '0;
          end else begin
            wcnt_d = wcnt + 1'b1;
          end
        end
        ST_RDATA: begin
          if (rcnt == 3'd0) begin
            mem_re = 1'b1;
            ptr_d  = page_next(ptr);
          end
          rcnt_d = (rcnt == (info_q.data_quad ? 3'd1 : 3'd7)) ? 3'd0 : rcnt + 3'd1;
        end
        ST_WDATA: begin
          sh_d  = sh_next;
          cnt_d = cnt + 5'd1;
          if (phase_last) begin
            cnt_d  = '0;
            mem_we = 1'b1;
            ptr_d  = page_next(ptr);
          end
        end
        default: state_d = ST_IGNORE;
      endcase
    end
  end

  // state registers
  always_ff @(posedge sclk or negedge rst_i) begin
    if (!rst_i) begin
      state  <= ST_CMD;
      armed  <= 1'b0;
      qpi    <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
      info_q <= '0;
      ptr    <= '0;
      wcnt   <= '0;
      rcnt   <= '0;
    end else begin
      state  <= state_d;
      armed  <= armed_d;
      qpi    <= qpi_d;
      cnt    <= cnt_d;
      shreg  <= sh_d;
      info_q <= info_d;
      ptr    <= ptr_d;
      wcnt   <= wcnt_d;
      rcnt   <= rcnt_d;
    end
  end

  psram_byte_store #(
    .ADDR_W (ADDR_W)
  ) i_store (
    .clk   (sclk),
    .we    (mem_we),
    .re    (mem_re),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  assign rd_active = (state == ST_RDATA) && !cs_n;

  psram_out_shifter i_out (
    .clk       (sclk),
    .rst_n     (rst_i),
    .active    (rd_active),
    .quad      (info_q.data_quad),
    .load_data (mem_rdata),
    .cs_n      (cs_n),
    .sio_out   (sio_out),
    .sio_oe    (sio_oe)
  );

  assign unused_bits = ^{shreg[SH_W-1], info_q.known, info_q.rd, info_q.go_quad,
                         info_q.go_one, dec.rd, dec.wr, dec.addr_quad,
                         dec.data_quad, dec.wait_clks};

  // R1: no activity before the device is armed
  a_r1_idle_until_armed: assert property (@(posedge sclk) disable iff (!rst_i)
    !armed |-> (state == ST_CMD && !mem_we && sio_oe == 4'b0000));

  // R2: the mode flag only moves at the end of an opcode phase
  a_r2_mode_moves_at_opcode: assert property (@(posedge sclk) disable iff (!rst_i)
    !$stable(qpi) |-> ($past(state) == ST_CMD));

  // R10: the falling-edge output stage is quiet whenever the decoder is not streaming
  a_r10_no_drive_outside_read: assert property (@(posedge sclk) disable iff (!rst_i)
    (state != ST_RDATA) |-> (sio_oe == 4'b0000));

  // R8: a burst write never leaves its page
  a_r8_page_held: assert property (@(posedge sclk) disable iff (!rst_i)
    mem_we |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

  // R12: deselect returns to the opcode phase with an empty bit count
  a_r12_deselect_to_opcode: assert property (@(posedge sclk) disable iff (!rst_i)
    cs_n |=> (state == ST_CMD && cnt == 5'd0));

  // R9: an unknown opcode keeps lanes and store untouched
  a_r9_unknown_is_quiet: assert property (@(posedge sclk) disable iff (!rst_i)
    (state == ST_IGNORE) |-> (!mem_we && sio_oe == 4'b0000));

endmodule

// File: tb/test_psram_serial_frontend.sv
module test_psram_serial_frontend;

  localparam int CLK_PERIOD = 20;
  localparam int AW         = 11;

  logic       sclk;
  logic       rst_n;
  logic       init_done;
  logic       cs_n;
  logic [3:0] sio_in;
  logic [3:0] sio_out;
  logic [3:0] sio_oe;

  psram_serial_frontend i_psram_serial_frontend (
    .sclk      (sclk),
    .rst_n     (rst_n),
    .init_done (init_done),
    .cs_n      (cs_n),
    .sio_in    (sio_in),
    .sio_out   (sio_out),
    .sio_oe    (sio_oe)
  );

  int          checks;
  int          failures;
  logic [7:0]  ref_mem [0:(1<<AW)-1];
  logic [7:0]  wbuf [0:15];
  logic [7:0]  rbuf [0:15];
  logic [3:0]  smp_out, smp_oe, post_out;
  logic        oe_bad;
  bit          qpi_m;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] wrap_next(input logic [AW-1:0] a);
    return {a[AW-1], a[9:0] + 10'd1};
  endfunction

  // one clock: drive while low, sample before the rise and again after it
  task automatic tick(input logic [3:0] din);
    sio_in = din;
    #(CLK_PERIOD/4);
    smp_out = sio_out;
    smp_oe  = sio_oe;
    #(CLK_PERIOD/4);
    sclk = 1'b1;
    #(CLK_PERIOD/4);
    post_out = sio_out;
    #(CLK_PERIOD/4);
    sclk = 1'b0;
  endtask

  task automatic send_field(input logic [31:0] v, input int nbits, input bit quad);
    if (quad) begin
      for (int i = 0; i < nbits/4; i++) begin
        tick(v[nbits-1-4*i -: 4]);
        if (smp_oe != 4'b0000) oe_bad = 1'b1;
      end
    end else begin
      for (int i = 0; i < nbits; i++) begin
        tick({3'b000, v[nbits-1-i]});
        if (smp_oe != 4'b0000) oe_bad = 1'b1;
      end
    end
  endtask

  task automatic quiet_clocks(input int n, input logic [3:0] din);
    for (int i = 0; i < n; i++) begin
      tick(din);
      if (smp_oe != 4'b0000) oe_bad = 1'b1;
    end
  endtask

  task automatic begin_txn();
    cs_n   = 1'b0;
    oe_bad = 1'b0;
  endtask

  task automatic end_txn();
    cs_n = 1'b1;
    tick(4'h0);
  endtask

  task automatic write_txn(input logic [7:0] op, input bit cq, input bit aq, input bit dq,
                           input logic [AW-1:0] a, input int n);
    logic [AW-1:0] p;
    begin_txn();
    send_field(32'(op), 8, cq);
    send_field(32'(a), 24, aq);
    p = a;
    for (int k = 0; k < n; k++) begin
      send_field(32'(wbuf[k]), 8, dq);
      ref_mem[p] = wbuf[k];
      p = wrap_next(p);
    end
    end_txn();
  endtask

  task automatic read_txn(input logic [7:0] op, input bit cq, input bit aq, input bit dq,
                          input int waitn, input logic [AW-1:0] a, input int n,
                          input string req);
    logic       bad_lane;
    logic       bad_stab;
    logic [7:0] by;
    logic [AW-1:0] p;
    bad_lane = 1'b0;
    bad_stab = 1'b0;
    begin_txn();
    send_field(32'(op), 8, cq);
    send_field(32'(a), 24, aq);
    quiet_clocks(waitn, 4'h0);
    check(!oe_bad, {req, " R10 lanes idle before data"}, 32'(oe_bad), 0);
    for (int k = 0; k < n; k++) begin
      by = '0;
      if (dq) begin
        for (int b = 0; b < 2; b++) begin
          tick(4'h0);
          by = {by[3:0], smp_out};
          if (smp_oe !== 4'b1111) bad_lane = 1'b1;
          if (post_out !== smp_out) bad_stab = 1'b1;
        end
      end else begin
        for (int b = 0; b < 8; b++) begin
          tick(4'h0);
          by = {by[6:0], smp_out[1]};
          if (smp_oe !== 4'b0010) bad_lane = 1'b1;
          if (post_out !== smp_out) bad_stab = 1'b1;
        end
      end
      rbuf[k] = by;
    end
    check(!bad_lane, {req, " lane enables during data"}, 32'(bad_lane), 0);
    check(!bad_stab, {req, " R11 data stable across rising edge"}, 32'(bad_stab), 0);
    cs_n = 1'b1;
    #1;
    check(sio_oe == 4'b0000, {req, " R10 enables drop at deselect"}, 32'(sio_oe), 0);
    tick(4'h0);
    p = a;
    for (int k = 0; k < n; k++) begin
      check(rbuf[k] === ref_mem[p], {req, " read byte"}, 32'(rbuf[k]), 32'(ref_mem[p]));
      p = wrap_next(p);
    end
  endtask

  task automatic set_mode(input bit quad);
    if (quad && !qpi_m) begin
      begin_txn(); send_field(32'h35, 8, 1'b0); end_txn();
    end else if (!quad && qpi_m) begin
      begin_txn(); send_field(32'hF5, 8, 1'b1); end_txn();
    end
    qpi_m = quad;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input int n, input int v);
    if (!qpi_m) begin
      if (v == 0) write_txn(8'h02, 1'b0, 1'b0, 1'b0, a, n);
      else        write_txn(8'h38, 1'b0, 1'b1, 1'b1, a, n);
    end else begin
      write_txn((v == 0) ? 8'h02 : 8'h38, 1'b1, 1'b1, 1'b1, a, n);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int n, input int v, input string req);
    if (!qpi_m) begin
      case (v)
        0:       read_txn(8'h03, 1'b0, 1'b0, 1'b0, 0, a, n, req);
        1:       read_txn(8'h0B, 1'b0, 1'b0, 1'b0, 8, a, n, req);
        default: read_txn(8'hEB, 1'b0, 1'b1, 1'b1, 6, a, n, req);
      endcase
    end else begin
      read_txn((v == 2) ? 8'hEB : 8'h0B, 1'b1, 1'b1, 1'b1, 6, a, n, req);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [AW-1:0] ra;
    int            rn;
    checks    = 0;
    failures  = 0;
    qpi_m     = 1'b0;
    sclk      = 1'b0;
    rst_n     = 1'b0;
    init_done = 1'b0;
    cs_n      = 1'b1;
    sio_in    = 4'h0;
    oe_bad    = 1'b0;
    void'($urandom(32'h5eed_0042));
    #(3*CLK_PERIOD);
    check(sio_oe == 4'b0000, "R10 reset leaves lanes undriven", 32'(sio_oe), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) tick(4'h0);

    // R1: before arming, a mode switch and a read must be ignored
    begin_txn(); send_field(32'h35, 8, 1'b0); cs_n = 1'b1; tick(4'h0);
    begin_txn();
    send_field(32'h03, 8, 1'b0);
    send_field(32'h10, 24, 1'b0);
    quiet_clocks(16, 4'h0);
    check(!oe_bad, "R1 no drive before ready", 32'(oe_bad), 0);
    cs_n = 1'b1; tick(4'h0);
    init_done = 1'b1;
    tick(4'h0);

    // R3 R4: single-lane write then plain read (also proves R1: mode untouched)
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
    do_write(11'h100, 4, 0);
    do_read(11'h100, 4, 0, "R3 R4 R1 single-lane write/read");

    // R5: fast read with 8 dummy clocks
    do_read(11'h101, 3, 1, "R5 fast read");

    // R6: quad write and quad read from single-lane mode
    wbuf[0] = 8'h3C; wbuf[1] = 8'h96; wbuf[2] = 8'hE7;
    do_write(11'h200, 3, 1);
    do_read(11'h200, 3, 2, "R6 quad read");

    // R8: bursts crossing the page end
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    do_write(11'h3FE, 4, 0);
    do_read(11'h000, 2, 0, "R8 wrap to page start");
    do_read(11'h3FF, 3, 2, "R8 read across wrap");
    wbuf[0] = 8'h5E; wbuf[1] = 8'hA7;
    do_write(11'h7FF, 2, 1);
    do_read(11'h400, 1, 1, "R8 upper page wrap");

    // R9: unknown opcode with toggling lanes leaves store alone
    begin_txn();
    send_field(32'h77, 8, 1'b0);
    quiet_clocks(24, 4'hF);
    check(!oe_bad, "R9 no drive after unknown opcode", 32'(oe_bad), 0);
    end_txn();
    do_read(11'h100, 2, 0, "R9 store unchanged");

    // R12: truncated write keeps only the complete byte
    begin_txn();
    send_field(32'h02, 8, 1'b0);
    send_field(32'h100, 24, 1'b0);
    send_field(32'h5A, 8, 1'b0);
    send_field(32'hF, 4, 1'b0);
    end_txn();
    ref_mem[11'h100] = 8'h5A;
    do_read(11'h100, 2, 0, "R12 partial byte dropped");

    // R2 R7: four-lane mode behaviour
    set_mode(1'b1);
    begin_txn(); send_field(32'h35, 8, 1'b1); end_txn();
    wbuf[0] = 8'hC0; wbuf[1] = 8'hDE;
    do_write(11'h300, 2, 0);
    do_read(11'h300, 2, 0, "R2 R7 quad mode held after repeated 35h");
    begin_txn();
    send_field(32'h03, 8, 1'b1);
    quiet_clocks(20, 4'h5);
    check(!oe_bad, "R7 03h unknown in four-lane mode", 32'(oe_bad), 0);
    end_txn();
    do_read(11'h100, 2, 2, "R7 EBh in four-lane mode");
    set_mode(1'b0);
    begin_txn(); send_field(32'hF5, 8, 1'b0); end_txn();
    do_read(11'h300, 2, 0, "R2 single-lane after F5h");

    // random write/read pairs
    for (int it = 0; it < 24; it++) begin
      if (($urandom % 4) == 0) set_mode(!qpi_m);
      ra = AW'($urandom % (1 << AW));
      rn = 1 + int'($urandom % 6);
      for (int k = 0; k < rn; k++) wbuf[k] = 8'($urandom);
      do_write(ra, rn, int'($urandom % 2));
      do_read(ra, rn, int'($urandom % 3), "R3 R6 R7 R8 random pair");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule